// File: doc/BRIEF.md
# Output Compare and PWM Channel

This block is one compare channel that sits beside a separate up-counting time base. It receives the current count, a tick that marks the cycles on which the count is live, an overflow strobe, the active period and the update-event pulse. It compares the count against a held compare value and builds an active-high reference waveform from a 3-bit mode. The reference then passes through a polarity inversion and an output enable to reach the pin.

The compare value is written through a simple write strobe. When preloading is off, a write takes effect on the next clock. When preloading is on, the write is parked and moves into the active compare register only on an update event. A single comparator serves all eight modes: hold, set on match, clear on match, toggle on match, forced low, forced high, and two edge-aligned PWM shapes.

A sticky match flag records compare events in every mode, including the forced ones. Software can also set the flag with a strobe and clear it with a clear strobe. The interrupt request is the flag gated by its enable bit.

Top module: `oc_pwm_channel`

## Requirements
- R1: After reset, the reference, the match flag, the interrupt request, the pin, the pin enable and the active compare value are all 0.
- R2: With `out_en`=1, `oc_pin` equals `oc_ref` XOR `polarity` and `oc_oe` is 1. With `out_en`=0, both `oc_pin` and `oc_oe` are 0.
- R3: In mode 3'b000 (hold), the reference keeps its level whatever the count does.
- R4: Mode 3'b001 drives the reference to 1 and mode 3'b010 drives it to 0. This happens one clock after a cycle in which `cnt_tick`=1 and `cnt` equals the active compare value. Without the tick there is no action.
- R5: In mode 3'b011, each qualifying match (tick with count equal to compare) inverts the reference one clock later.
- R6: Mode 3'b100 forces the reference to 0 and mode 3'b101 forces it to 1, one clock later, independent of the count.
- R7: In mode 3'b110, the reference one clock later is 1 exactly when `cnt` < active compare. Mode 3'b111 gives the inverse. So with a compare of 0 the reference stays 0 (mode 3'b110), and with a compare above `period` it stays 1.
- R8: With `preload_en`=0, a compare write appears in `cmp_active` one clock later. With `preload_en`=1, `cmp_active` is unchanged until an `upd` pulse, after which it holds the written value.
- R9: The match flag sets one clock after a tick with `cnt` equal to the active compare, in any mode including forced ones. When the active compare exceeds `period`, an `ovf` strobe sets it instead. When the compare does not exceed the period, `ovf` alone does not set it.
- R10: `sw_strobe` sets the match flag and `flag_clr` clears it. If both arrive in the same cycle, the set wins.
- R11: `irq` is 1 exactly when the match flag and `irq_en` are both 1.
- R12: In the non-PWM modes, an `upd` pulse leaves the reference level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt | input | W | Current count from the time base |
| cnt_tick | input | 1 | Count is live this cycle |
| ovf | input | 1 | Counter overflow strobe |
| upd | input | 1 | Update-event pulse |
| period | input | W | Active period (reload) value |
| cmp_wr | input | 1 | Compare write strobe |
| cmp_wdata | input | W | Compare write data |
| preload_en | input | 1 | Compare preload enable |
| mode | input | 3 | Reference mode select |
| polarity | input | 1 | 1 inverts the pin |
| out_en | input | 1 | Pin enable |
| sw_strobe | input | 1 | Software compare event |
| flag_clr | input | 1 | Clears the match flag |
| irq_en | input | 1 | Interrupt enable |
| oc_ref | output | 1 | Active-high reference waveform |
| oc_pin | output | 1 | Pin value after polarity and enable |
| oc_oe | output | 1 | Pin output enable |
| match_flag | output | 1 | Sticky compare-match flag |
| irq | output | 1 | Compare interrupt request |
| cmp_active | output | W | Active compare value |

## Verification
A wrong active compare value shows at `cmp_active` one clock after the write or update that should have set it. It also shifts the PWM edge and the match flag at the same count. A reference register that slips a state appears at `oc_ref` and `oc_pin` on the very next clock, because every mode rewrites or holds it each cycle. A flag path error shows on `match_flag` and `irq` one clock after the match, overflow or strobe that should have moved it.

// File: rtl/oc_pkg.sv
// Shared types for the compare channel: the reference mode encoding.
package oc_pkg;
    typedef enum logic [2:0] {
        OC_HOLD     = 3'b000,
        OC_SET      = 3'b001,
        OC_CLEAR    = 3'b010,
        OC_TOGGLE   = 3'b011,
        OC_FORCE_LO = 3'b100,
        OC_FORCE_HI = 3'b101,
        OC_PWM_A    = 3'b110,
        OC_PWM_B    = 3'b111
    } oc_mode_e;
endpackage

// File: rtl/oc_cmp_store.sv
// Compare value storage: a write register plus the active register that the
// comparator uses. Assumes upd is a single-cycle pulse from the time base.
module oc_cmp_store #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         preload_en,
    input  logic         upd,
    output logic [W-1:0] active
);
    logic [W-1:0] parked_q;

    // Capture every software write into the parked register.
    always_ff @(posedge clk) begin
        if (!rst_n)  parked_q <= '0;
        else if (wr) parked_q <= wdata;
    end

    // Move the value into the active register: directly, or on update when preloading.
    always_ff @(posedge clk) begin
        if (!rst_n)                  active <= '0;
        else if (!preload_en && wr)  active <= wdata;
        else if (preload_en && upd)  active <= parked_q;
    end
endmodule

// File: rtl/oc_comparator.sv
// Single comparator shared by all modes: equality, less-than and an
// above-period test. Purely combinational.
module oc_comparator #(
    parameter int W = 16
) (
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cmp,
    input  logic [W-1:0] period,
    output logic         eq,
    output logic         lt,
    output logic         above
);
    // Compare count and compare value, and compare value against the period.
    always_comb begin
        eq    = (cnt == cmp);
        lt    = (cnt < cmp);
        above = (cmp > period);
    end
endmodule

// File: rtl/oc_ref_gen.sv
// Reference waveform generator. Registers the next reference level from the
// mode and the comparator results. Assumes eq/lt come from the active compare.
module oc_ref_gen
    import oc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  oc_mode_e   mode,
    input  logic       tick,
    input  logic       eq,
    input  logic       lt,
    output logic       ref_q
);
    logic hit;
    logic ref_d;

    // Qualified match: only on a live counter cycle.
    always_comb hit = tick && eq;

    // Choose the next reference level for each mode.
    always_comb begin
        ref_d = ref_q;
        unique case (mode)
            OC_HOLD:     ref_d = ref_q;
            OC_SET:      if (hit) ref_d = 1'b1;
            OC_CLEAR:    if (hit) ref_d = 1'b0;
            OC_TOGGLE:   if (hit) ref_d = ~ref_q;
            OC_FORCE_LO: ref_d = 1'b0;
            OC_FORCE_HI: ref_d = 1'b1;
            OC_PWM_A:    ref_d = lt;
            OC_PWM_B:    ref_d = ~lt;
            default:     ref_d = ref_q;
        endcase
    end

    // Hold the reference level.
    always_ff @(posedge clk) begin
        if (!rst_n) ref_q <= 1'b0;
        else        ref_q <= ref_d;
    end
endmodule

// File: rtl/oc_flag.sv
// Sticky compare-match flag. Sets on a ticked match, on overflow when the
// compare lies above the period, or on a software strobe; set beats clear.
module oc_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic eq,
    input  logic above,
    input  logic ovf,
    input  logic sw_strobe,
    input  logic clr,
    output logic flag
);
    logic set_ev;

    // Collect every source that raises the flag.
    always_comb set_ev = (tick && eq) || (ovf && above) || sw_strobe;

    // Update the flag, with set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (set_ev) flag <= 1'b1;
        else if (clr)    flag <= 1'b0;
    end
endmodule

// File: rtl/oc_pwm_channel.sv
// Top of the compare channel. Connects the compare storage, the comparator,
// the reference generator and the flag, then applies polarity and enable.
// Assumes cnt, cnt_tick, ovf, upd and period come from one time base.
module oc_pwm_channel
    import oc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic         cnt_tick,
    input  logic         ovf,
    input  logic         upd,
    input  logic [W-1:0] period,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    input  logic         preload_en,
    input  logic [2:0]   mode,
    input  logic         polarity,
    input  logic         out_en,
    input  logic         sw_strobe,
    input  logic         flag_clr,
    input  logic         irq_en,
    output logic         oc_ref,
    output logic         oc_pin,
    output logic         oc_oe,
    output logic         match_flag,
    output logic         irq,
    output logic [W-1:0] cmp_active
);
    logic eq, lt, above;
    oc_mode_e mode_e;

    // Map the raw mode field onto the typed encoding.
    always_comb mode_e = oc_mode_e'(mode);

    oc_cmp_store #(.W(W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr(cmp_wr), .wdata(cmp_wdata),
        .preload_en(preload_en), .upd(upd), .active(cmp_active)
    );

    oc_comparator #(.W(W)) u_cmp (
        .cnt(cnt), .cmp(cmp_active), .period(period),
        .eq(eq), .lt(lt), .above(above)
    );

    oc_ref_gen u_ref (
        .clk(clk), .rst_n(rst_n), .mode(mode_e), .tick(cnt_tick),
        .eq(eq), .lt(lt), .ref_q(oc_ref)
    );

    oc_flag u_flag (
        .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .eq(eq), .above(above),
        .ovf(ovf), .sw_strobe(sw_strobe), .clr(flag_clr), .flag(match_flag)
    );

    // Pin stage: polarity, enable and interrupt gating.
    always_comb begin
        oc_oe  = out_en;
        oc_pin = out_en ? (oc_ref ^ polarity) : 1'b0;
        irq    = match_flag && irq_en;
    end
endmodule

// File: rtl/oc_pwm_channel_chk.sv
// Property checker for the compare channel, bound to the top module.
module oc_pwm_channel_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] cnt,
    input logic         cnt_tick,
    input logic         upd,
    input logic         cmp_wr,
    input logic [2:0]   mode,
    input logic         out_en,
    input logic         irq_en,
    input logic         oc_ref,
    input logic         oc_pin,
    input logic         oc_oe,
    input logic         match_flag,
    input logic         irq,
    input logic [W-1:0] cmp_active
);
    assert_pin_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (!oc_pin && !oc_oe));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b000) |=> (oc_ref == $past(oc_ref)));

    assert_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b001 && cnt_tick && cnt == cmp_active) |=> oc_ref);

    assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b010 && cnt_tick && cnt == cmp_active) |=> !oc_ref);

    assert_force_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b101) |=> oc_ref);

    assert_force_lo_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b100) |=> !oc_ref);

    assert_pwm_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b110) |=> (oc_ref == $past(cnt < cmp_active)));

    assert_cmp_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_wr && !upd) |=> $stable(cmp_active));

    assert_flag_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_tick && cnt == cmp_active) |=> match_flag);

    assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (match_flag && irq_en));
endmodule

bind oc_pwm_channel oc_pwm_channel_chk #(.W(W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_tick(cnt_tick), .upd(upd),
    .cmp_wr(cmp_wr), .mode(mode), .out_en(out_en), .irq_en(irq_en),
    .oc_ref(oc_ref), .oc_pin(oc_pin), .oc_oe(oc_oe), .match_flag(match_flag),
    .irq(irq), .cmp_active(cmp_active)
);

// File: tb/oc_pwm_channel_test.sv
module oc_pwm_channel_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;
    localparam int NVEC = 14;

    // Vector: {mode[2:0], cnt[15:0], tick, expected ref}; active compare is 5.
    localparam logic [20:0] VEC [NVEC] = '{
        {3'b001, 16'd5, 1'b1, 1'b1},  // R4 set on ticked match
        {3'b001, 16'd6, 1'b1, 1'b1},  // R4 no match, holds
        {3'b010, 16'd5, 1'b0, 1'b1},  // R4 no tick, no action
        {3'b010, 16'd5, 1'b1, 1'b0},  // R4 clear on match
        {3'b011, 16'd5, 1'b1, 1'b1},  // R5 toggle up
        {3'b011, 16'd5, 1'b1, 1'b0},  // R5 toggle down
        {3'b011, 16'd4, 1'b1, 1'b0},  // R5 no match
        {3'b101, 16'd0, 1'b0, 1'b1},  // R6 forced high
        {3'b000, 16'd5, 1'b1, 1'b1},  // R3 hold ignores match
        {3'b100, 16'd9, 1'b0, 1'b0},  // R6 forced low
        {3'b110, 16'd3, 1'b0, 1'b1},  // R7 below compare
        {3'b110, 16'd5, 1'b0, 1'b0},  // R7 at compare
        {3'b111, 16'd5, 1'b0, 1'b1},  // R7 inverse shape
        {3'b111, 16'd2, 1'b0, 1'b0}   // R7 inverse below
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic [W-1:0] cnt = '0, period = '0, cmp_wdata = '0;
    logic cnt_tick = 0, ovf = 0, upd = 0, cmp_wr = 0, preload_en = 0;
    logic [2:0] mode = 3'b000;
    logic polarity = 0, out_en = 0, sw_strobe = 0, flag_clr = 0, irq_en = 0;
    logic oc_ref, oc_pin, oc_oe, match_flag, irq;
    logic [W-1:0] cmp_active;
    int checks = 0, failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    oc_pwm_channel #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_tick(cnt_tick), .ovf(ovf),
        .upd(upd), .period(period), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
        .preload_en(preload_en), .mode(mode), .polarity(polarity),
        .out_en(out_en), .sw_strobe(sw_strobe), .flag_clr(flag_clr),
        .irq_en(irq_en), .oc_ref(oc_ref), .oc_pin(oc_pin), .oc_oe(oc_oe),
        .match_flag(match_flag), .irq(irq), .cmp_active(cmp_active)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cmp(input logic [W-1:0] v);
        cmp_wr = 1; cmp_wdata = v;
        step();
        cmp_wr = 0;
    endtask

    task automatic clear_flag();
        flag_clr = 1;
        step();
        flag_clr = 0;
    endtask

    function automatic string vec_req(input int i);
        case (i)
            0, 1, 2, 3: return "R4 table";
            4, 5, 6:    return "R5 table";
            7, 9:       return "R6 table";
            8:          return "R3 table";
            default:    return "R7 table";
        endcase
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        step(); step();
        check("R1 ref", oc_ref, 0);
        check("R1 flag", match_flag, 0);
        check("R1 pin", oc_pin, 0);
        check("R1 oe", oc_oe, 0);
        check("R1 irq", irq, 0);
        check("R1 cmp", cmp_active, 0);
        rst_n = 1; period = 16'd10;
        step();

        // R8 direct and preloaded compare writes
        write_cmp(16'd5);
        check("R8 direct write", cmp_active, 5);
        preload_en = 1;
        write_cmp(16'd7);
        step();
        check("R8 parked before update", cmp_active, 5);
        upd = 1; step(); upd = 0;
        check("R8 moved on update", cmp_active, 7);
        preload_en = 0;
        write_cmp(16'd5);
        out_en = 1;

        // Table walk over modes with compare 5
        for (int i = 0; i < NVEC; i++) begin
            mode = VEC[i][20:18]; cnt = VEC[i][17:2]; cnt_tick = VEC[i][1];
            step();
            check(vec_req(i), oc_ref, VEC[i][0]);
            check("R2 pin follows ref", oc_pin, VEC[i][0]);
        end
        cnt_tick = 0;

        // R7 saturation at zero and above period
        mode = 3'b110;
        write_cmp(16'd0);
        cnt = 16'd0; step();
        check("R7 compare zero at 0", oc_ref, 0);
        cnt = 16'd10; step();
        check("R7 compare zero at period", oc_ref, 0);
        write_cmp(16'd12);
        step();
        check("R7 compare above period", oc_ref, 1);
        mode = 3'b111; step();
        check("R7 inverse above period", oc_ref, 0);

        // R9 flag on overflow when compare above period
        clear_flag();
        check("R9 cleared", match_flag, 0);
        ovf = 1; step(); ovf = 0;
        check("R9 overflow above period", match_flag, 1);
        clear_flag();
        write_cmp(16'd5);
        ovf = 1; step(); ovf = 0;
        check("R9 overflow within period", match_flag, 0);
        mode = 3'b101; cnt = 16'd5; cnt_tick = 1; step(); cnt_tick = 0;
        check("R9 match in forced mode", match_flag, 1);
        check("R6 forced high ref", oc_ref, 1);
        clear_flag();

        // R10 software strobe and priority
        sw_strobe = 1; step(); sw_strobe = 0;
        check("R10 strobe sets", match_flag, 1);
        clear_flag();
        check("R10 clear", match_flag, 0);
        sw_strobe = 1; flag_clr = 1; step(); sw_strobe = 0; flag_clr = 0;
        check("R10 set wins", match_flag, 1);

        // R11 interrupt gating
        irq_en = 0; #1;
        check("R11 masked", irq, 0);
        irq_en = 1; #1;
        check("R11 enabled", irq, 1);
        clear_flag();
        check("R11 after clear", irq, 0);

        // R2 polarity and enable
        polarity = 1; #1;
        check("R2 inverted pin", oc_pin, 0);
        check("R2 oe on", oc_oe, 1);
        polarity = 0; #1;
        check("R2 plain pin", oc_pin, 1);
        out_en = 0; #1;
        check("R2 disabled pin", oc_pin, 0);
        check("R2 disabled oe", oc_oe, 0);
        out_en = 1;

        // R12 update event leaves non-PWM reference alone
        mode = 3'b001; cnt = 16'd0;
        preload_en = 1;
        write_cmp(16'd9);
        upd = 1; step(); upd = 0;
        check("R12 ref after update", oc_ref, 1);
        check("R12 compare moved", cmp_active, 9);
        mode = 3'b010;
        upd = 1; step(); upd = 0;
        check("R12 clear mode update", oc_ref, 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule